// File: doc/BRIEF.md
# Serial Register Write Port for a Multiplexed Display Controller

This block is the configuration front end of a seven-segment display controller. A host drives three pins: a serial clock, a serial data line and an active-low select line. While select is low, each rising serial clock edge pushes one data bit into a sixteen-bit frame register, most significant bit first. When select returns high, the frame held at that moment is decoded into a four-bit register address and an eight-bit data byte. The byte is written into one of eight digit registers or into one of the control registers: decode enable, brightness, scan limit, run/shutdown, feature and display test.

A serial output repeats the bit stream after a delay of sixteen and a half serial clocks and changes on falling serial clock edges. Several controllers can therefore share clock and select and be chained data-out to data-in. A frame with address zero passes through a controller without touching it. The three serial pins are asynchronous to the system clock. They are resynchronised through a flip-flop chain and all serial edges are detected in the system clock domain. The system clock must run several times faster than the serial clock.

Two writes carry side effects beyond storing a byte. A shutdown write may clear the feature register. A feature write with its reset bit set returns every other control register to its power-up value.

Top module: `display_serial_regs`

## Requirements
- R1: After reset, every digit register is 0x00, decode enable is 0x00, brightness is 0, scan limit is 0 (one digit), the run flag is 0 (shutdown), display test is 0 and the feature register is 0x00. The serial output is 0.
- R2: A frame is sixteen bits, first bit received is bit 15. Bits 11:8 are the address and bits 7:0 the data. Bits 15:12 have no effect on any register.
- R3: Addresses 1 through 8 write the whole data byte into digit registers 0 through 7. Digit k appears on digits_o[8k+7:8k]. The other digits are unchanged.
- R4: Address 9 writes the full byte to decode enable. Address 0xA stores data bits 3:0 as brightness. Address 0xB stores data bits 2:0 as scan limit. Address 0xF stores data bit 0 as display test. Unused data bits are dropped.
- R5: Address 0x0 and address 0xD change no register.
- R6: A write to address 0xC sets the run flag from data bit 0. When data bit 7 is 0 the feature register is cleared by the same write. When data bit 7 is 1 the feature register keeps its value.
- R7: A write to address 0xE stores the data byte in the feature register, with bit 1 always stored as 0. If data bit 1 is 1, the same write also returns decode enable, brightness, scan limit, run flag and display test to their R1 values. Digit registers keep their contents.
- R8: The serial output presents the bit that entered at rising serial clock k after the falling serial clock edge that follows rising edge k+16, which is sixteen and a half clocks later. It changes only on falling serial clock edges taken while select is low.
- R9: A rising edge on select commits the sixteen most recently shifted bits, whether more or fewer than sixteen were clocked in since select fell.
- R10: Serial clock edges while select is high shift nothing. A later select low-high pulse without clocks re-commits the unchanged frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_din_i | input | 1 | Serial data in, asynchronous |
| ser_csn_i | input | 1 | Active-low select and frame commit |
| ser_dout_o | output | 1 | Serial data out for chaining |
| digits_o | output | 64 | Eight digit registers, digit k at bits 8k+7:8k |
| decode_o | output | 8 | Per-digit decode enable |
| bright_o | output | 4 | Brightness level |
| scan_o | output | 3 | Index of last scanned digit |
| run_o | output | 1 | 1 = running, 0 = shutdown |
| test_o | output | 1 | Display test active |
| feature_o | output | 8 | Feature register |

## Verification
The write path is driven with full frames to every digit and control address. Frames with the ignored nibble set to all ones show that the upper bits never reach a register, and masked control bytes show which data bits each register keeps. A 32-bit burst under one select low period checks both the sixteen-and-a-half clock output delay and the rule that only the last sixteen bits commit. A frame of only eight bits shows that a short frame reuses older shift contents. Clocks sent with select high, followed by an empty select pulse, separate a shifter that wrongly runs while deselected from a correct one. Shutdown writes with bit 7 both clear and set, and feature writes with and without the reset bit, separate the conditional clear from the full control reset.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    localparam int FRAME_W    = 16;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 8;
    localparam int PAD_W      = FRAME_W - ADDR_W - DATA_W;
    localparam int NUM_DIGITS = 8;
    localparam int BRIGHT_W   = 4;
    localparam int SCAN_W     = 3;

    localparam logic [ADDR_W-1:0] ADDR_NOP    = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_DECODE = 4'h9;
    localparam logic [ADDR_W-1:0] ADDR_BRIGHT = 4'hA;
    localparam logic [ADDR_W-1:0] ADDR_SCAN   = 4'hB;
    localparam logic [ADDR_W-1:0] ADDR_POWER  = 4'hC;
    localparam logic [ADDR_W-1:0] ADDR_FEAT   = 4'hE;
    localparam logic [ADDR_W-1:0] ADDR_TEST   = 4'hF;

    localparam int FEAT_RESET_BIT = 1;
    localparam int POWER_KEEP_BIT = 7;
    localparam int POWER_RUN_BIT  = 0;

    typedef struct packed {
        logic [PAD_W-1:0]  pad;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef struct packed {
        logic [DATA_W-1:0]   decode;
        logic [BRIGHT_W-1:0] bright;
        logic [SCAN_W-1:0]   scan;
        logic                run;
        logic                test;
    } ctrl_t;

    function automatic ctrl_t ctrl_default();
        ctrl_t c;
        c.decode = '0;
        c.bright = '0;
        c.scan   = '0;
        c.run    = 1'b0;
        c.test   = 1'b0;
        return c;
    endfunction

    function automatic logic [ADDR_W-1:0] digit_addr(input int idx);
        return ADDR_W'(idx + 1);
    endfunction

endpackage

// File: rtl/dsr_sync.sv
module dsr_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);

    logic [W-1:0] pipe_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe_q[s] <= RST_VAL;
                    else     pipe_q[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe_q[s] <= RST_VAL;
                    else     pipe_q[s] <= pipe_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_o <= RST_VAL;
        else     prev_o <= pipe_q[STAGES-1];
    end

    assign sync_o = pipe_q[STAGES-1];

endmodule

// File: rtl/dsr_shift.sv
module dsr_shift
    import dsr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   shift_en,
    input  logic   out_en,
    input  logic   din,
    output frame_t frame_o,
    output logic   dout_o
);

    logic [FRAME_W-1:0] sh_q;
    logic               spill_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            spill_q <= 1'b0;
        end else if (shift_en) begin
            sh_q    <= {sh_q[FRAME_W-2:0], din};
            spill_q <= sh_q[FRAME_W-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         dout_o <= 1'b0;
        else if (out_en) dout_o <= spill_q;
    end

    assign frame_o = frame_t'(sh_q);

endmodule

// File: rtl/dsr_regfile.sv
module dsr_regfile
    import dsr_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           commit,
    input  frame_t                         frame,
    output logic [NUM_DIGITS*DATA_W-1:0]   digits_o,
    output ctrl_t                          ctrl_o,
    output logic [DATA_W-1:0]              feat_o
);

    logic [DATA_W-1:0] dig_q [NUM_DIGITS];

    generate
        for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
            always_ff @(posedge clk) begin
                if (rst)
                    dig_q[g] <= '0;
                else if (commit && frame.addr == digit_addr(g))
                    dig_q[g] <= frame.data;
            end
            assign digits_o[g*DATA_W +: DATA_W] = dig_q[g];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o <= ctrl_default();
            feat_o <= '0;
        end else if (commit) begin
            case (frame.addr)
                ADDR_DECODE: ctrl_o.decode <= frame.data;
                ADDR_BRIGHT: ctrl_o.bright <= frame.data[BRIGHT_W-1:0];
                ADDR_SCAN:   ctrl_o.scan   <= frame.data[SCAN_W-1:0];
                ADDR_TEST:   ctrl_o.test   <= frame.data[0];
                ADDR_POWER: begin
                    ctrl_o.run <= frame.data[POWER_RUN_BIT];
                    if (!frame.data[POWER_KEEP_BIT])
                        feat_o <= '0;
                end
                ADDR_FEAT: begin
                    feat_o <= frame.data & ~(DATA_W'(1) << FEAT_RESET_BIT);
                    if (frame.data[FEAT_RESET_BIT])
                        ctrl_o <= ctrl_default();
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/display_serial_regs.sv
module display_serial_regs
    import dsr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         ser_clk_i,
    input  logic                         ser_din_i,
    input  logic                         ser_csn_i,
    output logic                         ser_dout_o,
    output logic [NUM_DIGITS*DATA_W-1:0] digits_o,
    output logic [DATA_W-1:0]            decode_o,
    output logic [BRIGHT_W-1:0]          bright_o,
    output logic [SCAN_W-1:0]            scan_o,
    output logic                         run_o,
    output logic                         test_o,
    output logic [DATA_W-1:0]            feature_o
);

    localparam int PIN_CLK = 0;
    localparam int PIN_DIN = 1;
    localparam int PIN_CSN = 2;

    logic [2:0] pins_s, pins_p;
    logic       csn_s;
    logic       sclk_rise_p, sclk_fall_p, commit_p;
    logic       unused_prev_din;
    frame_t     frame_q;
    ctrl_t      ctrl_q;

    dsr_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({ser_csn_i, ser_din_i, ser_clk_i}),
        .sync_o  (pins_s),
        .prev_o  (pins_p)
    );

    assign csn_s           = pins_s[PIN_CSN];
    assign sclk_rise_p     = pins_s[PIN_CLK] & ~pins_p[PIN_CLK] & ~csn_s;
    assign sclk_fall_p     = ~pins_s[PIN_CLK] & pins_p[PIN_CLK] & ~csn_s;
    assign commit_p        = pins_s[PIN_CSN] & ~pins_p[PIN_CSN];
    assign unused_prev_din = pins_p[PIN_DIN];

    dsr_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (sclk_rise_p),
        .out_en   (sclk_fall_p),
        .din      (pins_s[PIN_DIN]),
        .frame_o  (frame_q),
        .dout_o   (ser_dout_o)
    );

    dsr_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit_p),
        .frame    (frame_q),
        .digits_o (digits_o),
        .ctrl_o   (ctrl_q),
        .feat_o   (feature_o)
    );

    assign decode_o = ctrl_q.decode;
    assign bright_o = ctrl_q.bright;
    assign scan_o   = ctrl_q.scan;
    assign run_o    = ctrl_q.run;
    assign test_o   = ctrl_q.test;

endmodule

// File: rtl/dsr_checker.sv
module dsr_checker
    import dsr_pkg::*;
(
    input logic                         clk,
    input logic                         rst,
    input logic                         csn_s,
    input logic                         sclk_fall_p,
    input logic                         commit_p,
    input frame_t                       frame_q,
    input logic                         ser_dout_o,
    input logic [NUM_DIGITS*DATA_W-1:0] digits_o,
    input logic [DATA_W-1:0]            decode_o,
    input logic [BRIGHT_W-1:0]          bright_o,
    input logic [SCAN_W-1:0]            scan_o,
    input logic                         run_o,
    input logic                         test_o,
    input logic [DATA_W-1:0]            feature_o
);

    p_reset_defaults_r1: assert property (@(posedge clk)
        rst |=> (digits_o == '0 && decode_o == '0 && bright_o == '0 &&
                 scan_o == '0 && !run_o && !test_o && feature_o == '0 && !ser_dout_o));

    p_dout_on_fall_r8: assert property (@(posedge clk) disable iff (rst)
        (ser_dout_o != $past(ser_dout_o)) |-> $past(sclk_fall_p));

    p_no_shift_deselected_r10: assert property (@(posedge clk) disable iff (rst)
        csn_s |=> $stable(frame_q));

    p_digits_only_on_commit_r3: assert property (@(posedge clk) disable iff (rst)
        !commit_p |=> $stable(digits_o));

    p_nop_holds_state_r5: assert property (@(posedge clk) disable iff (rst)
        (commit_p && (frame_q.addr == ADDR_NOP || frame_q.addr == 4'hD)) |=>
        ($stable(digits_o) && $stable(decode_o) && $stable(bright_o) && $stable(scan_o) &&
         $stable(run_o) && $stable(test_o) && $stable(feature_o)));

    p_power_clears_feature_r6: assert property (@(posedge clk) disable iff (rst)
        (commit_p && frame_q.addr == ADDR_POWER && !frame_q.data[POWER_KEEP_BIT]) |=>
        (feature_o == '0));

    p_feature_reset_r7: assert property (@(posedge clk) disable iff (rst)
        (commit_p && frame_q.addr == ADDR_FEAT && frame_q.data[FEAT_RESET_BIT]) |=>
        (decode_o == '0 && bright_o == '0 && scan_o == '0 && !run_o && !test_o &&
         $stable(digits_o) && !feature_o[FEAT_RESET_BIT]));

endmodule

bind display_serial_regs dsr_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .csn_s       (csn_s),
    .sclk_fall_p (sclk_fall_p),
    .commit_p    (commit_p),
    .frame_q     (frame_q),
    .ser_dout_o  (ser_dout_o),
    .digits_o    (digits_o),
    .decode_o    (decode_o),
    .bright_o    (bright_o),
    .scan_o      (scan_o),
    .run_o       (run_o),
    .test_o      (test_o),
    .feature_o   (feature_o)
);

// File: tb/display_serial_regs_test.sv
module display_serial_regs_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int WATCHDOG   = 150000;

    logic        clk  = 1'b0;
    logic        rst  = 1'b1;
    logic        sclk = 1'b0;
    logic        din  = 1'b0;
    logic        csn  = 1'b1;
    logic        dout;
    logic [63:0] digits;
    logic [7:0]  decode, feature;
    logic [3:0]  bright;
    logic [2:0]  scan;
    logic        run, test;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic rec [0:40];
    logic [7:0] exp_dig [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    display_serial_regs uut (
        .clk(clk), .rst(rst),
        .ser_clk_i(sclk), .ser_din_i(din), .ser_csn_i(csn),
        .ser_dout_o(dout), .digits_o(digits), .decode_o(decode),
        .bright_o(bright), .scan_o(scan), .run_o(run), .test_o(test),
        .feature_o(feature)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [31:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            din = w[n-1-i];
            wait_cyc(HALF);
            rec[i+1] = dout;
            sclk = 1'b1;
            wait_cyc(HALF);
            sclk = 1'b0;
        end
        wait_cyc(HALF);
        rec[n+1] = dout;
    endtask

    task automatic sel_low();
        csn = 1'b0;
        wait_cyc(HALF);
    endtask

    task automatic sel_high();
        csn = 1'b1;
        wait_cyc(HALF);
    endtask

    task automatic send(input logic [15:0] f);
        sel_low();
        shift_bits({16'h0, f}, 16);
        sel_high();
    endtask

    task automatic chk_digits(input string req);
        for (int i = 0; i < 8; i++)
            chk(req, digits[i*8 +: 8], exp_dig[i]);
    endtask

    task automatic t_reset_r1();
        chk("R1 digits", digits, 64'h0);
        chk("R1 decode", decode, 0);
        chk("R1 bright", bright, 0);
        chk("R1 scan", scan, 0);
        chk("R1 run", run, 0);
        chk("R1 test", test, 0);
        chk("R1 feature", feature, 0);
        chk("R1 dout", dout, 0);
    endtask

    task automatic t_digits_r2_r3();
        for (int i = 0; i < 8; i++) begin
            logic [7:0] v = 8'h11 * 8'(i + 1) ^ 8'h80;
            send({4'hF, 4'(i + 1), v});
            exp_dig[i] = v;
        end
        chk_digits("R3 digit write with pad ones (R2)");
        send({4'h0, 4'h3, 8'h5C});
        exp_dig[2] = 8'h5C;
        chk_digits("R3 single digit rewrite");
    endtask

    task automatic t_control_r4();
        send(16'hF9A5); chk("R4 decode", decode, 8'hA5);
        send(16'h0AF7); chk("R4 bright", bright, 4'h7);
        send(16'h0BFD); chk("R4 scan", scan, 3'h5);
        send(16'h0F03); chk("R4 test", test, 1);
        send(16'h0F02); chk("R4 test off", test, 0);
        chk_digits("R4 digits untouched");
    endtask

    task automatic t_nop_r5();
        logic [63:0] d0 = digits;
        logic [7:0]  dc = decode, ft = feature;
        logic [3:0]  br = bright;
        logic [2:0]  sc = scan;
        send(16'h00AB);
        send(16'hF0FF);
        send(16'h0DCD);
        chk("R5 digits", digits, d0);
        chk("R5 decode", decode, dc);
        chk("R5 bright", bright, br);
        chk("R5 scan", scan, sc);
        chk("R5 feature", feature, ft);
    endtask

    task automatic t_power_r6();
        send(16'h0EF5); chk("R7 feature store", feature, 8'hF5);
        send(16'h0C81); chk("R6 run on", run, 1);
        chk("R6 feature kept", feature, 8'hF5);
        send(16'h0C00); chk("R6 run off", run, 0);
        chk("R6 feature cleared", feature, 8'h00);
        send(16'h0E30);
        send(16'h0C01); chk("R6 run on keep=0", run, 1);
        chk("R6 feature cleared on enter run", feature, 8'h00);
    endtask

    task automatic t_feat_reset_r7();
        send(16'h09FF); send(16'h0A05); send(16'h0B07);
        send(16'h0C81); send(16'h0F01);
        send(16'h0E06);
        chk("R7 decode reset", decode, 0);
        chk("R7 bright reset", bright, 0);
        chk("R7 scan reset", scan, 0);
        chk("R7 run reset", run, 0);
        chk("R7 test reset", test, 0);
        chk("R7 feature bit1 zero", feature, 8'h04);
        chk_digits("R7 digits kept");
    endtask

    task automatic t_chain_r8_r9();
        logic [31:0] w = 32'hF4A5_0766;
        sel_low();
        shift_bits(w, 32);
        for (int r = 18; r <= 33; r++)
            chk($sformatf("R8 dout before rise %0d", r), rec[r], w[49-r]);
        sel_high();
        exp_dig[6] = 8'h66;
        chk_digits("R9 only last 16 bits commit");
    endtask

    task automatic t_short_r9();
        send(16'h0103);
        exp_dig[0] = 8'h03;
        sel_low();
        shift_bits(32'h5A, 8);
        sel_high();
        exp_dig[2] = 8'h5A;
        chk_digits("R9 short frame reuses older bits");
    endtask

    task automatic t_deselect_r10();
        logic [15:0] f = 16'h04EE;
        send(16'h0411);
        exp_dig[3] = 8'h11;
        for (int i = 0; i < 16; i++) begin
            din = f[15-i];
            wait_cyc(HALF);
            sclk = 1'b1;
            wait_cyc(HALF);
            sclk = 1'b0;
        end
        wait_cyc(HALF);
        sel_low();
        sel_high();
        chk_digits("R10 clocks ignored while deselected");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) exp_dig[i] = 8'h00;
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(5);
        t_reset_r1();
        t_digits_r2_r3();
        t_control_r4();
        t_nop_r5();
        t_power_r6();
        t_feat_reset_r7();
        t_chain_r8_r9();
        t_short_r9();
        t_deselect_r10();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule